// File: doc/BRIEF.md
# Five-Way Bus Arbiter with Favour and Block Controls

This block decides which of five bus masters owns a shared bus. Each master raises a request line and receives a one-hot grant line in return. Index 4 is the processor. Indices 0 to 3 are peripheral masters. A ten-bit control word is loaded through a simple write strobe. Each peripheral master has a block bit in the control word, and every master has a favour bit. A blocked master is never given the bus. A favoured master is given the bus on alternate issued grants. All other grants rotate fairly among the remaining eligible masters. The control word comes back on an output, along with an error flag and two summary flags: one for any favour set and one for any block set.

A grant lasts as long as its owner keeps requesting and stays unblocked. Once the owner lets go, the bus sits idle for one cycle, and the next decision is taken at the following edge. The block has an asynchronous active-low reset, and its release is synchronised inside the block. Coming out of reset, every peripheral is blocked and only the processor can be served, until software clears the block bits.

Top module: `bus_arb5`

## Requirements
- R1: During reset and after its release, cfg_q reads 0x055: the block bits of masters 0 to 3 are set and all favour bits are clear. gnt reads 0 and cfg_err reads 0. The internal reset is released on the second rising clock edge after rst_n rises, and the arbiter acts from the third edge on.
- R2: A cycle with cfg_we high loads cfg_wdata into cfg_q at the next edge. Master i (0 to 3) has its block bit at position 2i, and master i (0 to 4) has its favour bit at position 2i+1. Bit 8 always reads 0. When cfg_wdata carries more than one favour bit, only the favour bit of the lowest-indexed master is kept. Without a write, cfg_q holds its value.
- R3: cfg_err is registered together with each write. It is 1 if that write carried more than one favour bit and 0 otherwise, and it keeps that value until the next write.
- R4: any_pref is the OR of cfg_q under mask 0x2AA. any_deny is the OR of cfg_q under mask 0x055.
- R5: gnt is registered and has at most one bit set. A master that holds the bus keeps it for every cycle in which it still requests and is not blocked.
- R6: When the owner drops its request, gnt clears at the next edge. The bus then stays idle for one cycle, and a new owner can appear only at the edge after that.
- R7: A grant is never issued to a master whose block bit was set when the decision was taken. If a master's block bit is set while it holds the bus, its grant is withdrawn at the next edge.
- R8: When no favour bit is set, eligible masters are served in rotating order. The search starts one index above the last rotation winner, wraps from 4 to 0, and begins at master 0 after reset.
- R9: When a favour bit is set, a turn flag starts on the favoured side at reset and flips at every issued grant. On a favoured turn with the favoured master eligible, that master wins. Otherwise the other eligible masters are served in rotation, and the favoured master wins only when it is the sole eligible one. Grants to the favoured master do not move the rotation point.
- R10: Master 4 (the processor) has no block bit, so it can be granted straight out of reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 10 | Control word write data |
| cfg_q | output | 10 | Current control word |
| cfg_err | output | 1 | Last write carried more than one favour bit |
| any_pref | output | 1 | Some favour bit is set |
| any_deny | output | 1 | Some block bit is set |
| req | input | 5 | Request per master, bit 4 is the processor |
| gnt | output | 5 | One-hot grant per master |

## Verification
Two things can land on the same edge: a control word write that sets a block bit or moves the favour bit, and an arbitration decision or the release of a held grant. The stimulus provokes this by issuing random writes at random points while the masters toggle their requests at random, so block bits often arrive while their master holds the bus, and favour bits often move between two decisions. A behavioural model takes its decisions from the control word as it stood before the edge and then applies the write. The model is compared with gnt, cfg_q and the flags after every edge. This settles whether a decision used the old word or the new one, and whether a withdrawal took effect exactly one edge later.

// File: rtl/bus_arb5_pkg.sv
package bus_arb5_pkg;

  // Default geometry: four masters that can be blocked, plus the processor.
  localparam int unsigned DEF_N_BLK = 4;

  // Control word reset value: every block bit set, no favour bit set.
  function automatic logic [31:0] blk_mask(input int unsigned n_blk);
    logic [31:0] v;
    v = '0;
    for (int unsigned i = 0; i < n_blk; i++) v[2*i] = 1'b1;
    return v;
  endfunction

  // Positions of all favour bits (one per master, the processor included).
  function automatic logic [31:0] fav_mask(input int unsigned n_req);
    logic [31:0] v;
    v = '0;
    for (int unsigned i = 0; i < n_req; i++) v[2*i+1] = 1'b1;
    return v;
  endfunction

endpackage

// File: rtl/bus_arb5_rst_sync.sv
module bus_arb5_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);
  logic s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= 1'b1;
      s2_q <= s1_q;
    end
  end

  assign rst_n_s = s2_q;
endmodule

// File: rtl/bus_arb5_cfg.sv
module bus_arb5_cfg
  import bus_arb5_pkg::*;
#(
  parameter int unsigned N_BLK = DEF_N_BLK,
  localparam int unsigned N_REQ = N_BLK + 1,
  localparam int unsigned CW    = 2 * N_REQ
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CW-1:0]    wdata,
  output logic [CW-1:0]    word_q,
  output logic [N_REQ-1:0] blk_vec,
  output logic [N_REQ-1:0] fav_vec,
  output logic             err_q,
  output logic             any_fav,
  output logic             any_blk
);
  localparam logic [CW-1:0] RST_WORD = CW'(blk_mask(N_BLK));
  localparam logic [CW-1:0] FAV_MSK  = CW'(fav_mask(N_REQ));

  logic [N_REQ-1:0] fav_in, fav_keep;
  logic [CW-1:0]    word_d;
  logic             err_d;
  logic             seen;

  // Pick out the favour field and keep only its lowest-indexed bit.
  always_comb begin
    seen = 1'b0;
    for (int unsigned i = 0; i < N_REQ; i++) begin
      fav_in[i]   = wdata[2*i+1];
      fav_keep[i] = fav_in[i] & ~seen;
      seen        = seen | fav_in[i];
    end
  end

  // Next state.
  always_comb begin
    word_d = word_q;
    err_d  = err_q;
    if (we) begin
      word_d = '0;
      for (int unsigned i = 0; i < N_BLK; i++) word_d[2*i] = wdata[2*i];
      for (int unsigned i = 0; i < N_REQ; i++) word_d[2*i+1] = fav_keep[i];
      err_d = ($countones(fav_in) > 1);
    end
  end

  // Register, clock-enabled by the write strobe.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= RST_WORD;
      err_q  <= 1'b0;
    end else if (we) begin
      word_q <= word_d;
      err_q  <= err_d;
    end
  end

  // Decoded views of the stored word.
  generate
    for (genvar g = 0; g < N_REQ; g++) begin : g_dec
      if (g < N_BLK) begin : g_blk
        assign blk_vec[g] = word_q[2*g];
      end else begin : g_noblk
        assign blk_vec[g] = 1'b0;
      end
      assign fav_vec[g] = word_q[2*g+1];
    end
  endgenerate

  assign any_fav = |(word_q & FAV_MSK);
  assign any_blk = |(word_q & RST_WORD);

  // R2
  fav_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> ($countones(fav_vec) <= 1));

  // R2
  word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(word_q));

  // R3
  err_kept_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> ($countones(fav_vec) == 1));
endmodule

// File: rtl/bus_arb5_rr.sv
module bus_arb5_rr #(
  parameter  int unsigned N   = 5,
  localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     cand,
  input  logic [IDX_W-1:0] last,
  output logic             hit,
  output logic [IDX_W-1:0] idx
);
  int unsigned j;

  // Search upward from the index just above the last winner, wrapping.
  always_comb begin
    hit = 1'b0;
    idx = '0;
    j   = 0;
    for (int unsigned k = 1; k <= N; k++) begin
      j = int'(last) + k;
      if (j >= N) j = j - N;
      if (!hit && cand[j]) begin
        hit = 1'b1;
        idx = IDX_W'(j);
      end
    end
  end
endmodule

// File: rtl/bus_arb5_core.sv
module bus_arb5_core #(
  parameter  int unsigned N_REQ = 5,
  localparam int unsigned IDX_W = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_REQ-1:0] req,
  input  logic [N_REQ-1:0] blk_vec,
  input  logic [N_REQ-1:0] fav_vec,
  output logic [N_REQ-1:0] gnt_q
);
  localparam logic [IDX_W-1:0] LAST_RST = IDX_W'(N_REQ - 1);

  logic             busy_q, busy_d;
  logic [IDX_W-1:0] own_q, own_d;
  logic             turn_q, turn_d;
  logic [IDX_W-1:0] last_q, last_d;
  logic [N_REQ-1:0] gnt_d;

  logic [N_REQ-1:0] elig, others;
  logic             fav_on;
  logic [IDX_W-1:0] fav_idx;
  logic             rr_hit;
  logic [IDX_W-1:0] rr_idx;
  logic             issue, pick_rr, hold;
  logic [IDX_W-1:0] pick;

  assign elig   = req & ~blk_vec;
  assign others = elig & ~fav_vec;
  assign fav_on = |fav_vec;

  always_comb begin
    fav_idx = '0;
    for (int unsigned i = 0; i < N_REQ; i++)
      if (fav_vec[i]) fav_idx = IDX_W'(i);
  end

  bus_arb5_rr #(.N(N_REQ)) u_rr (
    .cand (others),
    .last (last_q),
    .hit  (rr_hit),
    .idx  (rr_idx)
  );

  // Decision for an idle bus.
  always_comb begin
    issue   = |elig;
    pick_rr = 1'b0;
    pick    = fav_idx;
    if (fav_on && turn_q && elig[fav_idx]) begin
      pick = fav_idx;
    end else if (rr_hit) begin
      pick    = rr_idx;
      pick_rr = 1'b1;
    end
  end

  assign hold = busy_q & req[own_q] & ~blk_vec[own_q];

  // Next state.
  always_comb begin
    busy_d = busy_q;
    own_d  = own_q;
    turn_d = turn_q;
    last_d = last_q;
    gnt_d  = gnt_q;
    if (busy_q) begin
      if (!hold) begin
        busy_d = 1'b0;
        gnt_d  = '0;
      end
    end else if (issue) begin
      busy_d = 1'b1;
      own_d  = pick;
      gnt_d  = N_REQ'(1) << pick;
      turn_d = ~turn_q;
      if (pick_rr) last_d = pick;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      own_q  <= '0;
      turn_q <= 1'b1;
      last_q <= LAST_RST;
      gnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      own_q  <= own_d;
      turn_q <= turn_d;
      last_q <= last_d;
      gnt_q  <= gnt_d;
    end
  end

  // R5
  gnt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt_q));

  // R5
  gnt_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((gnt_q & req & ~blk_vec) != '0) |=> (gnt_q == $past(gnt_q)));

  // R6
  gnt_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((gnt_q != '0) && ((gnt_q & req) == '0)) |=> (gnt_q == '0));

  // R7
  gnt_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((gnt_q == '0) && (elig != '0)) |=> ((gnt_q & $past(blk_vec)) == '0));
endmodule

// File: rtl/bus_arb5.sv
module bus_arb5
  import bus_arb5_pkg::*;
#(
  parameter  int unsigned N_BLK = DEF_N_BLK,
  localparam int unsigned N_REQ = N_BLK + 1,
  localparam int unsigned CW    = 2 * N_REQ
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CW-1:0]    cfg_wdata,
  output logic [CW-1:0]    cfg_q,
  output logic             cfg_err,
  output logic             any_pref,
  output logic             any_deny,
  input  logic [N_REQ-1:0] req,
  output logic [N_REQ-1:0] gnt
);
  logic             rst_n_s;
  logic [N_REQ-1:0] blk_vec, fav_vec;

  bus_arb5_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_s (rst_n_s)
  );

  bus_arb5_cfg #(.N_BLK(N_BLK)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .we      (cfg_we),
    .wdata   (cfg_wdata),
    .word_q  (cfg_q),
    .blk_vec (blk_vec),
    .fav_vec (fav_vec),
    .err_q   (cfg_err),
    .any_fav (any_pref),
    .any_blk (any_deny)
  );

  bus_arb5_core #(.N_REQ(N_REQ)) u_core (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .req     (req),
    .blk_vec (blk_vec),
    .fav_vec (fav_vec),
    .gnt_q   (gnt)
  );

  // R10
  cpu_unblocked_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    !blk_vec[N_REQ-1]);
endmodule

// File: tb/bus_arb5_tb_top.sv
module bus_arb5_tb_top;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [9:0] cfg_wdata = '0;
  logic [9:0] cfg_q;
  logic       cfg_err, any_pref, any_deny;
  logic [4:0] req = '0;
  logic [4:0] gnt;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  bit cmp_en = 1'b0;
  string tag = "R1";

  always #(CLK_P/2) clk = ~clk;

  bus_arb5 dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_q(cfg_q), .cfg_err(cfg_err), .any_pref(any_pref), .any_deny(any_deny),
    .req(req), .gnt(gnt)
  );

  // ---------------- behavioural reference ----------------
  int m_ctrl, m_err, m_busy, m_own, m_turn, m_last;
  int m_sync;   // rising edges seen since reset release, saturates at 2

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctrl = 'h055; m_err = 0; m_busy = 0; m_own = 0;
      m_turn = 1; m_last = 4; m_sync = 0;
    end else if (m_sync < 2) begin
      m_sync = m_sync + 1;
    end else begin
      int fav, blk[5], elig[5], ch, nfav, w;
      fav = -1;
      for (int i = 0; i < 5; i++) begin
        blk[i]  = (i < 4) ? ((m_ctrl >> (2*i)) & 1) : 0;
        if ((m_ctrl >> (2*i+1)) & 1) fav = i;
        elig[i] = (req[i] && !blk[i]) ? 1 : 0;
      end
      if (m_busy != 0) begin
        if (!(req[m_own] && blk[m_own] == 0)) m_busy = 0;
      end else if (elig[0] + elig[1] + elig[2] + elig[3] + elig[4] > 0) begin
        if (fav >= 0 && m_turn != 0 && elig[fav] != 0) ch = fav;
        else begin
          ch = -1;
          for (int k = 1; k <= 5; k++) begin
            int j;
            j = (m_last + k) % 5;
            if (ch < 0 && elig[j] != 0 && j != fav) ch = j;
          end
          if (ch >= 0) m_last = ch;
          else ch = fav;
        end
        m_busy = 1; m_own = ch; m_turn = 1 - m_turn;
      end
      if (cfg_we) begin
        nfav = 0; w = 0;
        for (int i = 0; i < 4; i++) w = w | (cfg_wdata[2*i] << (2*i));
        for (int i = 0; i < 5; i++)
          if (cfg_wdata[2*i+1]) begin
            if (nfav == 0) w = w | (1 << (2*i+1));
            nfav = nfav + 1;
          end
        m_ctrl = w;
        m_err  = (nfav > 1) ? 1 : 0;
      end
    end
  end

  task automatic check(input bit ok, input string rq, input string what,
                       input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h t=%0t", rq, what, act, exp, $time);
    end
  endtask

  // Per-edge comparison, a quarter period after the edge.
  always @(posedge clk) begin
    #(CLK_P/4);
    if (cmp_en) begin
      int eg;
      eg = (m_busy != 0) ? (1 << m_own) : 0;
      check(int'(gnt) == eg, tag, "gnt", int'(gnt), eg);
      check(int'(cfg_q) == m_ctrl, "R2", "cfg_q", int'(cfg_q), m_ctrl);
      check(int'(cfg_err) == m_err, "R3", "cfg_err", int'(cfg_err), m_err);
      check(int'(any_pref) == ((m_ctrl & 'h2AA) != 0), "R4", "any_pref",
            int'(any_pref), int'((m_ctrl & 'h2AA) != 0));
      check(int'(any_deny) == ((m_ctrl & 'h055) != 0), "R4", "any_deny",
            int'(any_deny), int'((m_ctrl & 'h055) != 0));
    end
  end

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  task automatic wr(input int v);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = 10'(v);
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic rand_phase(input int n, input bit rand_wr);
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      req = 5'(~($urandom & $urandom));
      cfg_we = 1'b0;
      if (rand_wr && ($urandom % 23 == 0)) begin
        cfg_we = 1'b1;
        cfg_wdata = 10'($urandom);
      end
    end
    @(negedge clk); cfg_we = 1'b0;
  endtask

  initial begin
    // R1: reset state, including release timing
    repeat (3) @(negedge clk);
    check(cfg_q == 10'h055 && gnt == 0 && !cfg_err, "R1", "reset word",
          int'(cfg_q), 'h055);
    req = 5'h1F;
    rst_n = 1'b1;
    cmp_en = 1'b1;
    @(negedge clk); @(negedge clk);
    check(gnt == 0, "R1", "no grant before third edge", int'(gnt), 0);
    @(negedge clk);
    // R10: processor served while peripherals are blocked (R7)
    check(gnt == 5'h10, "R10", "cpu granted from reset", int'(gnt), 'h10);
    req = 5'h0F;
    @(negedge clk);
    check(gnt == 0, "R6", "release after drop", int'(gnt), 0);
    @(negedge clk);
    check(gnt == 0, "R7", "blocked peripherals not granted", int'(gnt), 0);

    // R8: plain rotation
    tag = "R8";
    wr('h000);
    req = 5'h1F;
    @(negedge clk); @(negedge clk);
    check(gnt == 5'h01, "R8", "rotation starts at 0", int'(gnt), 'h01);
    rand_phase(400, 1'b0);

    // R9: processor favoured, then a peripheral favoured
    tag = "R9";
    wr('h200);
    rand_phase(400, 1'b0);
    wr('h008);
    rand_phase(400, 1'b0);

    // R2/R3: conflicting favour write keeps lowest
    tag = "R9";
    req = 5'h00;
    wr('h2AA);
    @(negedge clk);
    check(cfg_q == 10'h002 && cfg_err, "R3", "conflict kept lowest, flagged",
          int'(cfg_q), 'h002);
    rand_phase(300, 1'b0);

    // R7: mixed blocks
    tag = "R7";
    wr('h041);
    rand_phase(300, 1'b0);

    // Writes racing with decisions and releases
    tag = "R5";
    rand_phase(3000, 1'b1);

    req = 5'h00;
    @(negedge clk); @(negedge clk);
    finish_run();
  end
endmodule